// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit core whose instructions are all one 32-bit word. In each cycle it classifies the current instruction word into one of six control-flow kinds and forms the address of the following instruction. It then loads that address into the PC register on the next clock edge. The kinds are: sequential flow, branch-if-equal, branch-if-different, absolute jump, jump that records a return address, and jump through a register. The datapath around it supplies two things: a flag saying whether the two register operands of the instruction compare equal, and the value read from the first source register.

The next address is offered combinationally on `next_pc`. For the return-address jump, the block also raises a write request towards the return-address register and presents the value to write. A register-indirect jump whose target is not word aligned raises a flag. The target is still taken with its two low bits cleared, so fetch never leaves word alignment. There are no delay slots, no exceptions and no prediction: the address produced is simply the architectural successor.

The six flow kinds play the part of states, with these names: `FLOW_SEQ`, `FLOW_BEQ`, `FLOW_BNE`, `FLOW_JMP`, `FLOW_JAL`, `FLOW_JR`. The transition is the same in every kind: on each clock the PC register moves to `next_pc`. Asynchronous reset forces the PC to `RESET_PC`.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst_n` is low the PC is `RESET_PC` (default 0), and it stays there until the first clock edge after release.
- R2: On every rising clock edge with reset released, `pc` takes the value `next_pc` had just before the edge. For any opcode (instr[31:26]) not listed in R3 to R7, `next_pc` is `pc + 4`, wrapping modulo 2^32.
- R3: Opcode 4 (branch-if-equal): when `ops_equal` is 1, `next_pc = pc + 4 + (sign-extended instr[15:0] shifted left by 2)`; when 0, `next_pc = pc + 4`.
- R4: Opcode 5 (branch-if-different) uses the same target as R3, but is taken when `ops_equal` is 0; when `ops_equal` is 1, `next_pc = pc + 4`.
- R5: Opcode 2 (jump): `next_pc = {pc[31:28], instr[25:0], 2'b00}`; a field of 2500 therefore gives offset 10000 inside the current 256 MB region.
- R6: Opcode 3 (jump with return address) goes to the same target as R5, drives `link_we` high with `link_value = pc + 4` and `link_reg = 31`. `link_we` is low for every other instruction.
- R7: Opcode 0 with function code 8 in instr[5:0] (register jump): `next_pc = {rs_value[31:2], 2'b00}`. Opcode 0 with any other function code is sequential.
- R8: `misalign` is 1 exactly when a register jump (R7) sees `rs_value[1:0]` nonzero, and 0 for every other instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word at the current PC |
| ops_equal | input | 1 | 1 when the two register operands are equal |
| rs_value | input | 32 | Value of the first source register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Write request for the return-address register |
| link_reg | output | 5 | Index of the register to write (31) |
| link_value | output | 32 | Return address, pc + 4 |
| misalign | output | 1 | Register-jump target not word aligned |

## Verification
The bench builds the unit with its default parameters: reset address 0 and return register 31. It uses register jumps to move the PC anywhere in the 32-bit space, which makes several cases reachable. A jump with field 2500 can be taken from the upper 256 MB region, so the kept PC bits must come from the current PC. The PC can also be parked at the last word to show wrap-around to zero. Branch offsets at both extremes of the 16-bit field (0x7FFF and 0x8000) exercise sign extension. A misaligned register target checks that the clear of the low bits and the flag agree.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
    localparam int XLEN      = 32;
    localparam int OPC_W     = 6;
    localparam int FUNCT_W   = 6;
    localparam int IMM_W     = 16;
    localparam int JIDX_W    = 26;
    localparam int REGIDX_W  = 5;
    localparam int KEEP_W    = XLEN - JIDX_W - 2;
    localparam int STEP      = XLEN / 8;

    localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_JMP     = 6'd2;
    localparam logic [OPC_W-1:0]   OPC_JAL     = 6'd3;
    localparam logic [OPC_W-1:0]   OPC_BEQ     = 6'd4;
    localparam logic [OPC_W-1:0]   OPC_BNE     = 6'd5;
    localparam logic [FUNCT_W-1:0] FN_JR       = 6'd8;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL,
        FLOW_JR
    } flow_e;
endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FUNCT_W-1:0] funct,
    output flow_e              flow
);
    always_comb begin
        unique case (opcode)
            OPC_BEQ:     flow = FLOW_BEQ;
            OPC_BNE:     flow = FLOW_BNE;
            OPC_JMP:     flow = FLOW_JMP;
            OPC_JAL:     flow = FLOW_JAL;
            OPC_SPECIAL: flow = (funct == FN_JR) ? FLOW_JR : FLOW_SEQ;
            default:     flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
    import nxpc_pkg::*;
(
    input  logic [XLEN-1:0]   pc,
    input  logic [JIDX_W-1:0] jfield,
    input  logic [XLEN-1:0]   rs_value,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   jmp_pc,
    output logic [XLEN-1:0]   jr_pc,
    output logic              jr_odd
);
    localparam int EXT_W = XLEN - IMM_W - 2;

    logic [XLEN-1:0] br_disp;

    always_comb begin
        seq_pc  = pc + XLEN'(STEP);
        br_disp = {{EXT_W{jfield[IMM_W-1]}}, jfield[IMM_W-1:0], 2'b00};
        br_pc   = seq_pc + br_disp;
        jmp_pc  = {pc[XLEN-1 -: KEEP_W], jfield, 2'b00};
        jr_pc   = {rs_value[XLEN-1:2], 2'b00};
        jr_odd  = |rs_value[1:0];
    end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import nxpc_pkg::*;
#(
    parameter logic [XLEN-1:0]     RESET_PC = '0,
    parameter logic [REGIDX_W-1:0] LINK_REG = 5'd31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     instr,
    input  logic                ops_equal,
    input  logic [XLEN-1:0]     rs_value,
    output logic [XLEN-1:0]     pc,
    output logic [XLEN-1:0]     next_pc,
    output logic                link_we,
    output logic [REGIDX_W-1:0] link_reg,
    output logic [XLEN-1:0]     link_value,
    output logic                misalign
);
    flow_e           flow;
    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, jr_pc;
    logic            jr_odd;

    nxpc_decode u_decode (
        .opcode (instr[XLEN-1 -: OPC_W]),
        .funct  (instr[FUNCT_W-1:0]),
        .flow   (flow)
    );

    nxpc_target u_target (
        .pc       (pc),
        .jfield   (instr[JIDX_W-1:0]),
        .rs_value (rs_value),
        .seq_pc   (seq_pc),
        .br_pc    (br_pc),
        .jmp_pc   (jmp_pc),
        .jr_pc    (jr_pc),
        .jr_odd   (jr_odd)
    );

    // PC register: moves to the selected successor every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= next_pc;
    end

    // Successor selection and side outputs per flow kind
    always_comb begin
        next_pc    = seq_pc;
        link_we    = 1'b0;
        misalign   = 1'b0;
        link_reg   = LINK_REG;
        link_value = seq_pc;
        unique case (flow)
            FLOW_SEQ: next_pc = seq_pc;
            FLOW_BEQ: next_pc = ops_equal ? br_pc : seq_pc;
            FLOW_BNE: next_pc = ops_equal ? seq_pc : br_pc;
            FLOW_JMP: next_pc = jmp_pc;
            FLOW_JAL: begin
                next_pc = jmp_pc;
                link_we = 1'b1;
            end
            FLOW_JR: begin
                next_pc  = jr_pc;
                misalign = jr_odd;
            end
            default: next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/nxpc_checker.sv
module nxpc_checker
    import nxpc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OPC_W-1:0] opcode,
    input logic            ops_equal,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] next_pc,
    input logic            link_we,
    input logic [XLEN-1:0] link_value,
    input logic            misalign
);
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc == RESET_PC);

    a_r2_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pc == $past(next_pc));

    a_r3_beq_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BEQ && !ops_equal) |-> next_pc == pc + 32'd4);

    a_r4_bne_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BNE && ops_equal) |-> next_pc == pc + 32'd4);

    a_r5_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_JMP || opcode == OPC_JAL) |-> next_pc[31:28] == pc[31:28]);

    a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_value == pc + 32'd4 && opcode == OPC_JAL));

    a_r8_misalign_clean: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (next_pc[1:0] == 2'b00 && !link_we && opcode == OPC_SPECIAL));
endmodule

bind next_pc_unit nxpc_checker #(.RESET_PC(RESET_PC)) u_nxpc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (instr[31:26]),
    .ops_equal  (ops_equal),
    .pc         (pc),
    .next_pc    (next_pc),
    .link_we    (link_we),
    .link_value (link_value),
    .misalign   (misalign)
);

// File: tb/tb_next_pc_unit.sv
`timescale 1ns/1ps
module tb_next_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        ops_equal = 1'b0;
    logic [31:0] rs_value = '0;
    logic [31:0] pc, next_pc, link_value;
    logic        link_we, misalign;
    logic [4:0]  link_reg;

    next_pc_unit dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .ops_equal(ops_equal),
        .rs_value(rs_value), .pc(pc), .next_pc(next_pc), .link_we(link_we),
        .link_reg(link_reg), .link_value(link_value), .misalign(misalign)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [31:0] npc;
        logic [31:0] lval;
        logic        lwe;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t  sbq[$];
    event  mon_ev;
    int    total = 0;
    int    fails = 0;
    bit    done = 0;
    logic [31:0] mpc = 32'h0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] p, input logic [31:0] ins,
                                   input logic eq, input logic [31:0] rsv);
        exp_t e;
        logic [31:0] seq, bt, jt;
        seq = p + 32'd4;
        bt  = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
        jt  = {p[31:28], ins[25:0], 2'b00};
        e.npc = seq; e.lval = seq; e.lwe = 1'b0; e.mis = 1'b0; e.tag = "";
        case (ins[31:26])
            6'd4: if (eq)  e.npc = bt;
            6'd5: if (!eq) e.npc = bt;
            6'd2: e.npc = jt;
            6'd3: begin e.npc = jt; e.lwe = 1'b1; end
            6'd0: if (ins[5:0] == 6'd8) begin
                e.npc = {rsv[31:2], 2'b00};
                e.mis = |rsv[1:0];
            end
            default: ;
        endcase
        return e;
    endfunction

    // Driver: apply one instruction, push expected outputs, then advance a clock
    task automatic step(input logic [31:0] ins, input logic eq,
                        input logic [31:0] rsv, input string tag);
        exp_t e;
        check(pc === mpc, "R2", pc, mpc);
        instr = ins; ops_equal = eq; rs_value = rsv;
        e = model(mpc, ins, eq, rsv);
        e.tag = tag;
        sbq.push_back(e);
        #2; -> mon_ev; #1;
        @(posedge clk);
        mpc = e.npc;
        @(negedge clk);
    endtask

    // Monitor: compare design outputs against the scoreboard head
    initial begin
        forever begin
            exp_t e;
            @(mon_ev);
            e = sbq.pop_front();
            check(next_pc === e.npc, e.tag, next_pc, e.npc);
            check(link_we === e.lwe, "R6", {31'b0, link_we}, {31'b0, e.lwe});
            if (e.lwe) begin
                check(link_value === e.lval, "R6", link_value, e.lval);
                check(link_reg === 5'd31, "R6", {27'b0, link_reg}, 32'd31);
            end
            check(misalign === e.mis, "R8", {31'b0, misalign}, {31'b0, e.mis});
        end
    end

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd9, 5'd10, imm};
    endfunction

    function automatic logic [31:0] jtype(input logic [5:0] op, input logic [25:0] f);
        return {op, f};
    endfunction

    function automatic logic [31:0] rtype(input logic [5:0] fn);
        return {6'd0, 5'd17, 5'd0, 5'd0, 5'd0, fn};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(pc === 32'h0, "R1", pc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pc === 32'h4, "R1", pc, 32'h4);  // instr=0 is sequential after release
        mpc = 32'h4;

        step(rtype(6'd0), 1'b0, 32'h0, "R7");              // opcode 0, funct 0: sequential
        step(itype(6'h23, 16'h0010), 1'b1, 32'h0, "R2");   // other opcode: sequential
        step(itype(6'd4, 16'h0003), 1'b1, 32'h0, "R3");    // taken forward
        step(itype(6'd4, 16'h0003), 1'b0, 32'h0, "R3");    // not taken
        step(itype(6'd5, 16'hFFFE), 1'b0, 32'h0, "R4");    // taken backward
        step(itype(6'd5, 16'h0040), 1'b1, 32'h0, "R4");    // not taken
        step(jtype(6'd2, 26'd2500), 1'b0, 32'h0, "R5");    // -> 10000
        step(jtype(6'd3, 26'h40), 1'b0, 32'h0, "R6");      // call -> 0x100
        step(rtype(6'd8), 1'b0, 32'h3000_0000, "R7");      // into high region
        step(jtype(6'd2, 26'd2500), 1'b0, 32'h0, "R5");    // -> 0x30002710
        step(jtype(6'd3, 26'h3FF_FFFF), 1'b1, 32'h0, "R6");
        step(rtype(6'd8), 1'b0, 32'h0000_1003, "R8");      // misaligned target
        step(itype(6'd4, 16'h7FFF), 1'b1, 32'h0, "R3");    // largest forward
        step(itype(6'd4, 16'h8000), 1'b1, 32'h0, "R3");    // largest backward
        step(rtype(6'd9), 1'b0, 32'h0000_4002, "R7");      // other funct: sequential
        step(rtype(6'd8), 1'b0, 32'hFFFF_FFFC, "R7");
        step(rtype(6'd0), 1'b0, 32'h0, "R2");              // wraps to 0
        check(pc === 32'h0, "R2", pc, 32'h0);

        rst_n = 1'b0;
        #1;
        check(pc === 32'h0, "R1", pc, 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule